// File: doc/BRIEF.md
# Interrupt Controller Host Command Port

This block is the processor-facing side of an eight-input programmable interrupt controller. It watches a chip select, separate read and write strobes, one address line and an 8-bit data bus. Every write is sorted into one of four kinds: a setup start byte, a priority command, a read-control command, or a byte for the odd address. A small sequencer steers odd-address bytes into the later setup bytes (vector base, cascade configuration, mode configuration) while a setup is in progress, and into the mask register once setup is complete.

The pending-request and in-service vectors come in from the priority logic. A read returns the mask register, or one of those two vectors, as chosen by the last read-control command. The decoded setup fields, the lowest-priority input number and the last priority command are exported as registered outputs. A one-cycle strobe marks each new priority command, so that a separate priority resolver can act on them.

Write strobes are synchronized to the core clock, and a write takes effect on the rising edge of the synchronized strobe. Address and data must stay stable while the strobe is low. The read path is combinational and comes with an enable for an external tri-state driver.

The sequencer has five states. S_UNINIT is the state after reset, before any setup. S_WANT_BASE waits for the vector base byte. S_WANT_CASC waits for the cascade byte. S_WANT_MODE waits for the mode byte. S_READY is normal operation. Its transitions are:
- from any state to S_WANT_BASE on a start byte;
- from S_WANT_BASE to S_WANT_CASC when cascade is expected, otherwise to S_WANT_MODE when a mode byte is expected, otherwise to S_READY;
- from S_WANT_CASC to S_WANT_MODE or S_READY;
- from S_WANT_MODE to S_READY.

Top module: `irq_cmd_port`

## Requirements
- R1: A write with a0=0 and data bit 4 = 1 is a start byte. From any state it restarts setup: `ready` falls and the sequencer waits for the vector base byte.
- R2: A start byte sets the mask to 0x00, `lowest_q` to 7, `casc_cfg_q` to 0x07, `spec_mask_q` to 0 and `mode_cfg_q` to 0, and makes a0=0 reads return the pending-request vector.
- R3: After a start byte, odd-address writes load, in order, `vec_base_q`, then `casc_cfg_q`, then `mode_cfg_q`. Start bit 1 = 1 (single) skips the cascade byte. Start bit 0 = 1 requires the mode byte. `ready` rises when the last required byte is taken.
- R4: In S_READY, an a0=1 write loads the mask register (`mask_q`).
- R5: In S_READY, an a0=0 write with bits 4:3 = 00 is a priority command. It loads `prio_cmd_q`, pulses `prio_cmd_stb` for exactly one cycle, and when bits 7 and 6 are both 1 it sets `lowest_q` to bits 2:0. Otherwise `lowest_q` keeps its value.
- R6: In S_READY, an a0=0 write with bits 4:3 = 01 is a read-control command. When bit 1 = 1, bit 0 selects in-service (1) or pending (0) for a0=0 reads; when bit 1 = 0 the selection is kept. When bit 6 = 1, `spec_mask_q` takes bit 5.
- R7: While cs_n=0 and rd_n=0, `dout_oe` is 1 and `dout` shows the mask for a0=1, or the selected vector for a0=0. It follows register updates made during the read.
- R8: When cs_n=1 or rd_n=1, `dout_oe` and `dout` are 0. A write strobe with cs_n=1 changes nothing.
- R9: Before setup completes, priority and read-control writes are ignored, and odd-address writes in S_UNINIT are ignored.
- R10: A start byte loads `level_mode_q` from bit 3 and `single_q` from bit 1. The mode byte loads bits 4:0 into `mode_cfg_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Address line |
| din | input | 8 | Write data |
| req_in | input | 8 | Pending-request vector |
| svc_in | input | 8 | In-service vector |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data enable for the bus driver |
| ready | output | 1 | Setup complete |
| mask_q | output | 8 | Interrupt mask |
| vec_base_q | output | 8 | Vector base byte |
| casc_cfg_q | output | 8 | Cascade configuration byte |
| mode_cfg_q | output | 5 | Mode configuration bits |
| level_mode_q | output | 1 | Level-triggered select from the start byte |
| single_q | output | 1 | Single-controller select from the start byte |
| prio_cmd_q | output | 8 | Last priority command |
| prio_cmd_stb | output | 1 | One-cycle pulse per new priority command |
| lowest_q | output | 3 | Input number holding the lowest priority |
| spec_mask_q | output | 1 | Special mask mode |

## Verification
A read can be open at the same moment that a write commits, because `dout` is combinational from registers that the synchronized write path updates. The bench holds a read of the odd address open, then issues a mask write on the same select without closing the read. It checks that the old mask is still shown right after the write strobe falls, and that the new mask appears once the synchronized commit has passed, with `dout_oe` high throughout. The restart case is also covered: a start byte sent in the middle of normal operation must undo several non-default registers in one cycle.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int PRIO_W = 3;
    localparam int MODE_W = 5;

    typedef enum logic [2:0] {
        S_UNINIT,
        S_WANT_BASE,
        S_WANT_CASC,
        S_WANT_MODE,
        S_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        K_START,
        K_PRIO,
        K_RDCTL,
        K_PORT1
    } wr_kind_t;
endpackage

// File: rtl/irq_wr_sync.sv
module irq_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic fire
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= !cs_n && !wr_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign fire = sync_q[LAST] && !prev_q;
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_cmd_pkg::*;
(
    input  logic     a0,
    input  logic     d4,
    input  logic     d3,
    output wr_kind_t kind
);
    always_comb begin
        if (a0)      kind = K_PORT1;
        else if (d4) kind = K_START;
        else if (d3) kind = K_RDCTL;
        else         kind = K_PRIO;
    end
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  wr_kind_t   kind,
    input  logic       d_single,
    input  logic       d_need_mode,
    output seq_state_t state,
    output logic       ready,
    output logic       start,
    output logic       ld_base,
    output logic       ld_casc,
    output logic       ld_mode,
    output logic       ld_mask,
    output logic       ld_prio,
    output logic       ld_rdctl
);
    seq_state_t state_q, state_d;
    logic       want_casc_q, want_mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_UNINIT;
            want_casc_q <= 1'b0;
            want_mode_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                want_casc_q <= !d_single;
                want_mode_q <= d_need_mode;
            end
        end
    end

    // next state and load strobes
    always_comb begin
        state_d  = state_q;
        start    = 1'b0;
        ld_base  = 1'b0;
        ld_casc  = 1'b0;
        ld_mode  = 1'b0;
        ld_mask  = 1'b0;
        ld_prio  = 1'b0;
        ld_rdctl = 1'b0;
        if (fire) begin
            if (kind == K_START) begin
                start   = 1'b1;
                state_d = S_WANT_BASE;
            end else begin
                unique case (state_q)
                    S_UNINIT: ;
                    S_WANT_BASE: if (kind == K_PORT1) begin
                        ld_base = 1'b1;
                        if (want_casc_q)      state_d = S_WANT_CASC;
                        else if (want_mode_q) state_d = S_WANT_MODE;
                        else                  state_d = S_READY;
                    end
                    S_WANT_CASC: if (kind == K_PORT1) begin
                        ld_casc = 1'b1;
                        state_d = want_mode_q ? S_WANT_MODE : S_READY;
                    end
                    S_WANT_MODE: if (kind == K_PORT1) begin
                        ld_mode = 1'b1;
                        state_d = S_READY;
                    end
                    S_READY: begin
                        ld_mask  = (kind == K_PORT1);
                        ld_prio  = (kind == K_PRIO);
                        ld_rdctl = (kind == K_RDCTL);
                    end
                    default: state_d = S_UNINIT;
                endcase
            end
        end
    end

    assign state = state_q;
    assign ready = (state_q == S_READY);
endmodule

// File: rtl/irq_cmd_regs.sv
module irq_cmd_regs
    import irq_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              start,
    input  logic              ld_base,
    input  logic              ld_casc,
    input  logic              ld_mode,
    input  logic              ld_mask,
    input  logic              ld_prio,
    input  logic              ld_rdctl,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] vec_base_q,
    output logic [DATA_W-1:0] casc_cfg_q,
    output logic [MODE_W-1:0] mode_cfg_q,
    output logic              level_mode_q,
    output logic              single_q,
    output logic [DATA_W-1:0] prio_cmd_q,
    output logic              prio_cmd_stb,
    output logic [PRIO_W-1:0] lowest_q,
    output logic              spec_mask_q,
    output logic              rd_svc_q
);
    localparam logic [PRIO_W-1:0] LOWEST_DEF = PRIO_W'((1 << PRIO_W) - 1);
    localparam logic [DATA_W-1:0] CASC_DEF   = DATA_W'((1 << PRIO_W) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q       <= '0;
            vec_base_q   <= '0;
            casc_cfg_q   <= CASC_DEF;
            mode_cfg_q   <= '0;
            level_mode_q <= 1'b0;
            single_q     <= 1'b0;
            prio_cmd_q   <= '0;
            prio_cmd_stb <= 1'b0;
            lowest_q     <= LOWEST_DEF;
            spec_mask_q  <= 1'b0;
            rd_svc_q     <= 1'b0;
        end else begin
            prio_cmd_stb <= ld_prio;
            if (start) begin
                mask_q       <= '0;
                casc_cfg_q   <= CASC_DEF;
                mode_cfg_q   <= '0;
                lowest_q     <= LOWEST_DEF;
                spec_mask_q  <= 1'b0;
                rd_svc_q     <= 1'b0;
                level_mode_q <= din[3];
                single_q     <= din[1];
            end
            if (ld_base) vec_base_q <= din;
            if (ld_casc) casc_cfg_q <= din;
            if (ld_mode) mode_cfg_q <= din[MODE_W-1:0];
            if (ld_mask) mask_q     <= din;
            if (ld_prio) begin
                prio_cmd_q <= din;
                if (din[7] && din[6]) lowest_q <= din[PRIO_W-1:0];
            end
            if (ld_rdctl) begin
                if (din[1]) rd_svc_q    <= din[0];
                if (din[6]) spec_mask_q <= din[5];
            end
        end
    end
endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
    import irq_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] svc_in,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              ready,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] vec_base_q,
    output logic [DATA_W-1:0] casc_cfg_q,
    output logic [MODE_W-1:0] mode_cfg_q,
    output logic              level_mode_q,
    output logic              single_q,
    output logic [DATA_W-1:0] prio_cmd_q,
    output logic              prio_cmd_stb,
    output logic [PRIO_W-1:0] lowest_q,
    output logic              spec_mask_q
);
    logic       fire, start;
    logic       ld_base, ld_casc, ld_mode, ld_mask, ld_prio, ld_rdctl;
    logic       rd_svc_q;
    wr_kind_t   kind;
    seq_state_t state;

    irq_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .fire(fire)
    );

    irq_wr_decode u_dec (
        .a0(a0), .d4(din[4]), .d3(din[3]), .kind(kind)
    );

    irq_init_seq u_seq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .kind(kind),
        .d_single(din[1]), .d_need_mode(din[0]),
        .state(state), .ready(ready), .start(start),
        .ld_base(ld_base), .ld_casc(ld_casc), .ld_mode(ld_mode),
        .ld_mask(ld_mask), .ld_prio(ld_prio), .ld_rdctl(ld_rdctl)
    );

    irq_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .din(din), .start(start),
        .ld_base(ld_base), .ld_casc(ld_casc), .ld_mode(ld_mode),
        .ld_mask(ld_mask), .ld_prio(ld_prio), .ld_rdctl(ld_rdctl),
        .mask_q(mask_q), .vec_base_q(vec_base_q), .casc_cfg_q(casc_cfg_q),
        .mode_cfg_q(mode_cfg_q), .level_mode_q(level_mode_q),
        .single_q(single_q), .prio_cmd_q(prio_cmd_q),
        .prio_cmd_stb(prio_cmd_stb), .lowest_q(lowest_q),
        .spec_mask_q(spec_mask_q), .rd_svc_q(rd_svc_q)
    );

    assign dout_oe = !cs_n && !rd_n;

    always_comb begin
        if (!dout_oe)      dout = '0;
        else if (a0)       dout = mask_q;
        else if (rd_svc_q) dout = svc_in;
        else               dout = req_in;
    end
endmodule

// File: rtl/irq_cmd_port_chk.sv
module irq_cmd_port_chk
    import irq_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              ready,
    input logic              start,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] casc_cfg_q,
    input logic [PRIO_W-1:0] lowest_q,
    input logic              spec_mask_q,
    input logic              prio_cmd_stb
);
    p_start_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    p_start_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mask_q == '0 && lowest_q == '1 && !spec_mask_q
                   && casc_cfg_q == DATA_W'((1 << PRIO_W) - 1)));

    p_mask_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !start) |=> $stable(mask_q));

    p_cmd_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prio_cmd_stb |=> !prio_cmd_stb);

    p_cmd_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prio_cmd_stb |-> ready);

    p_bus_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!dout_oe && dout == '0));
endmodule

bind irq_cmd_port irq_cmd_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .dout(dout), .dout_oe(dout_oe), .ready(ready), .start(start),
    .mask_q(mask_q), .casc_cfg_q(casc_cfg_q), .lowest_q(lowest_q),
    .spec_mask_q(spec_mask_q), .prio_cmd_stb(prio_cmd_stb)
);

// File: tb/test_irq_cmd_port.sv
module test_irq_cmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = 8'h00, req_in = 8'h3C, svc_in = 8'h81;
    logic [7:0] dout, mask_q, vec_base_q, casc_cfg_q, prio_cmd_q;
    logic [4:0] mode_cfg_q;
    logic [2:0] lowest_q;
    logic       dout_oe, ready, level_mode_q, single_q, prio_cmd_stb, spec_mask_q;
    int         checks = 0, errors = 0, stb_count = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    irq_cmd_port i_irq_cmd_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .req_in(req_in), .svc_in(svc_in),
        .dout(dout), .dout_oe(dout_oe), .ready(ready), .mask_q(mask_q),
        .vec_base_q(vec_base_q), .casc_cfg_q(casc_cfg_q),
        .mode_cfg_q(mode_cfg_q), .level_mode_q(level_mode_q),
        .single_q(single_q), .prio_cmd_q(prio_cmd_q),
        .prio_cmd_stb(prio_cmd_stb), .lowest_q(lowest_q),
        .spec_mask_q(spec_mask_q)
    );

    always @(negedge clk) if (prio_cmd_stb) stb_count++;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d, input logic sel_cs = 1'b1);
        @(negedge clk);
        cs_n = !sel_cs; a0 = sel; din = d; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic sel, output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = sel;
        #1 v = dout; oe = dout_oe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] v; logic oe;
        check("R8 idle oe", {7'b0, dout_oe}, 8'h00);
        check("R8 idle dout", dout, 8'h00);
        check("R1 ready after reset", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h55);
        rd(1'b1, v, oe);
        check("R9 uninit port1 ignored", v, 8'h00);
        check("R7 read oe", {7'b0, oe}, 8'h01);
    endtask

    task automatic t_full_init;
        logic [7:0] v; logic oe;
        wr(1'b0, 8'h11);
        check("R1 start clears ready", {7'b0, ready}, 8'h00);
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'h40);
        check("R3 base loaded", vec_base_q, 8'h40);
        check("R3 casc pending", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h04);
        check("R3 casc loaded", casc_cfg_q, 8'h04);
        check("R3 mode pending", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h03);
        check("R10 mode loaded", {3'b0, mode_cfg_q}, 8'h03);
        check("R3 ready after mode", {7'b0, ready}, 8'h01);
        rd(1'b0, v, oe);
        check("R9 early rdctl ignored", v, 8'h3C);
        check("R9 mask untouched by setup", mask_q, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] v; logic oe;
        wr(1'b1, 8'hA5);
        check("R4 mask reg", mask_q, 8'hA5);
        rd(1'b1, v, oe);
        check("R7 mask read", v, 8'hA5);
        wr(1'b1, 8'hFF, 1'b0);
        rd(1'b1, v, oe);
        check("R8 deselected write ignored", v, 8'hA5);
    endtask

    task automatic t_rdctl;
        logic [7:0] v; logic oe;
        wr(1'b0, 8'h0B);
        rd(1'b0, v, oe);
        check("R6 select svc", v, 8'h81);
        wr(1'b0, 8'h08);
        rd(1'b0, v, oe);
        check("R6 no-read bit keeps select", v, 8'h81);
        wr(1'b0, 8'h0A);
        rd(1'b0, v, oe);
        check("R6 select req", v, 8'h3C);
        wr(1'b0, 8'h68);
        check("R6 special mask on", {7'b0, spec_mask_q}, 8'h01);
        wr(1'b0, 8'h0B);
    endtask

    task automatic t_prio;
        int base;
        base = stb_count;
        wr(1'b0, 8'hC5);
        check("R5 cmd stored", prio_cmd_q, 8'hC5);
        check("R5 lowest set", {5'b0, lowest_q}, 8'h05);
        check("R5 one pulse", 8'(stb_count - base), 8'h01);
        wr(1'b0, 8'h20);
        check("R5 cmd stored 2", prio_cmd_q, 8'h20);
        check("R5 lowest kept", {5'b0, lowest_q}, 8'h05);
        check("R5 two pulses", 8'(stb_count - base), 8'h02);
    endtask

    task automatic t_restart;
        logic [7:0] v; logic oe;
        wr(1'b0, 8'h1A);
        check("R1 restart drops ready", {7'b0, ready}, 8'h00);
        check("R2 mask cleared", mask_q, 8'h00);
        check("R2 lowest 7", {5'b0, lowest_q}, 8'h07);
        check("R2 casc 7", casc_cfg_q, 8'h07);
        check("R2 special mask off", {7'b0, spec_mask_q}, 8'h00);
        check("R2 mode cleared", {3'b0, mode_cfg_q}, 8'h00);
        check("R10 level bit", {7'b0, level_mode_q}, 8'h01);
        check("R10 single bit", {7'b0, single_q}, 8'h01);
        rd(1'b0, v, oe);
        check("R2 read select req", v, 8'h3C);
        wr(1'b1, 8'h08);
        check("R3 two byte ready", {7'b0, ready}, 8'h01);
        check("R3 casc skipped", casc_cfg_q, 8'h07);
    endtask

    task automatic t_single_mode;
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h20);
        check("R3 waits mode", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h1F);
        check("R10 mode all", {3'b0, mode_cfg_q}, 8'h1F);
        check("R3 ready single+mode", {7'b0, ready}, 8'h01);
        check("R3 casc skipped 2", casc_cfg_q, 8'h07);
        check("R10 level clear", {7'b0, level_mode_q}, 8'h00);
    endtask

    task automatic t_overlap;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = 1'b1;
        #1 check("R7 overlap before", dout, 8'h00);
        din = 8'h5A; wr_n = 1'b0;
        #1 check("R7 overlap old held", dout, 8'h00);
        repeat (4) @(negedge clk);
        #1 check("R7 overlap new", dout, 8'h5A);
        check("R7 overlap oe", {7'b0, dout_oe}, 8'h01);
        wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_init();
        t_mask();
        t_rdctl();
        t_prio();
        t_restart();
        t_single_mode();
        t_overlap();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule